// File: doc/BRIEF.md
# Prescaled Software Watchdog Timer

This block is a software watchdog timer that runs from the system clock. Software keeps the system alive by writing a two-byte key sequence to a service port before a selectable time-out runs out. If it fails to do so, the block raises a single-cycle reset request for the system reset controller and sets a sticky status flag. That flag tells software after the restart that the watchdog caused the reset.

The time-out is set by three configuration bits. A prescale select bit puts a fixed divide-by-2^PRE_LOG2 prescaler (512 by default) ahead of the time-out counter. A two-bit timing code `t` picks a counter length of 2^(EXP_BASE + 2t) ticks. At the defaults this gives eight power-of-two periods:

- With no prescale: 2^9, 2^11, 2^13 and 2^15 clocks.
- With the prescaler: 2^18, 2^20, 2^22 and 2^24 clocks.

An enable bit stops the count entirely. Configuration is captured only at well-defined restart points, so a stray write to it cannot shorten or stretch a count that is already running.

Top module: `sft_watchdog`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `wdt_rst_req` = 0 and `wdt_flag` = 0, and the count restarts from zero.
- R2: With the captured prescale bit 0 and timing code t (0..3, read as an unsigned number), `wdt_rst_req` first goes high exactly 2^(EXP_BASE+2t) rising edges after the restart edge (2^9, 2^11, 2^13, 2^15 at defaults).
- R3: With the captured prescale bit 1, the period is multiplied by 2^PRE_LOG2, giving 2^(PRE_LOG2+EXP_BASE+2t) edges (2^18, 2^20, 2^22, 2^24 at defaults).
- R4: `wdt_rst_req` is high for exactly one cycle per expiry. The edge that raises it also restarts the count, so a further expiry follows one full period later.
- R5: `wdt_flag` goes high with the first reset request and stays high, through services and further expiries, until `rst`.
- R6: A service write of 0x55 followed by a write of 0xAA (`svc_we` high on both cycles; idle cycles between them allowed) clears the counter and the prescaler at the 0xAA edge. The next expiry is then one full period after that edge.
- R7: After a 0x55, any written value other than 0x55 or 0xAA breaks the sequence, and a following 0xAA does not service. A 0xAA with no preceding 0x55 does not service. A repeated 0x55 keeps the sequence armed.
- R8: While `cfg_en` is 0, the counter and prescaler are held at zero and no reset request is produced. After `cfg_en` returns to 1, the expiry comes one full period after the first enabled edge.
- R9: `cfg_pre` and `cfg_tsel` are captured only at a reset edge, a completed service, or an expiry. A change in mid-count does not alter the running period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Watchdog enable |
| cfg_pre | input | 1 | Prescale select: 1 divides the tick by 2^PRE_LOG2 |
| cfg_tsel | input | 2 | Timing code t, period 2^(EXP_BASE+2t) ticks |
| svc_we | input | 1 | Service write strobe |
| svc_data | input | 8 | Service write data |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request (registered) |
| wdt_flag | output | 1 | Sticky watchdog-reset flag (registered) |

## Verification
The assertions assume that `rst` is applied at time zero and held for at least one edge. They also assume the parameters keep every period at two or more clock cycles, so a request pulse can never be followed at once by another. The bench holds reset for several edges, keeps EXP_BASE at 4 with a 3-bit prescaler, and changes all inputs only on falling edges. The completed-service property relies on the sequence detector's internal completion strobe. The bench therefore issues key writes only through its own service task, which drives exactly one value per cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  localparam int TSEL_W   = 2;
  localparam int EXP_STEP = 2;

  typedef struct packed {
    logic                pre;
    logic [TSEL_W-1:0]   tsel;
  } wdt_cfg_t;

endpackage

// File: rtl/wdt_svc_seq.sv
module wdt_svc_seq
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] data,
  output logic       kick
);

  logic armed_q;

  assign kick = we && armed_q && (data == KEY_FIRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (we) begin
      armed_q <= (data == KEY_ARM);
    end
  end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_LOG2 = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic divide,
  output logic tick
);

  localparam int PW = (PRE_LOG2 < 1) ? 1 : PRE_LOG2;
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  logic [PW-1:0] pcnt_q;

  assign tick = run && (!divide || (pcnt_q == PMAX));

  always_ff @(posedge clk) begin
    if (rst || clr || !run || !divide) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
  import wdt_pkg::*;
#(
  parameter int EXP_BASE = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic              tick,
  input  logic [TSEL_W-1:0] tsel,
  output logic              expire
);

  localparam int MAX_EXP = EXP_BASE + EXP_STEP * ((1 << TSEL_W) - 1);
  localparam int CW      = MAX_EXP + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_val;

  always_comb begin
    last_val = (CW'(1) << (EXP_BASE + EXP_STEP * int'(tsel))) - CW'(1);
  end

  assign expire = run && tick && !clr && (cnt_q == last_val);

  always_ff @(posedge clk) begin
    if (rst || clr || !run || expire) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sft_watchdog.sv
module sft_watchdog
  import wdt_pkg::*;
#(
  parameter int PRE_LOG2 = 9,
  parameter int EXP_BASE = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_en,
  input  logic       cfg_pre,
  input  logic [1:0] cfg_tsel,
  input  logic       svc_we,
  input  logic [7:0] svc_data,
  output logic       wdt_rst_req,
  output logic       wdt_flag
);

  wdt_cfg_t cfg_q;
  logic     svc_kick;
  logic     tick;
  logic     expire;

  wdt_svc_seq u_seq (
    .clk  (clk),
    .rst  (rst),
    .we   (svc_we),
    .data (svc_data),
    .kick (svc_kick)
  );

  wdt_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr    (svc_kick),
    .run    (cfg_en),
    .divide (cfg_q.pre),
    .tick   (tick)
  );

  wdt_timebase #(.EXP_BASE(EXP_BASE)) u_tb (
    .clk    (clk),
    .rst    (rst),
    .clr    (svc_kick),
    .run    (cfg_en),
    .tick   (tick),
    .tsel   (cfg_q.tsel),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst || svc_kick || expire) begin
      cfg_q.pre  <= cfg_pre;
      cfg_q.tsel <= cfg_tsel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_rst_req <= 1'b0;
      wdt_flag    <= 1'b0;
    end else begin
      wdt_rst_req <= expire;
      if (expire) begin
        wdt_flag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdt_checks.sv
module wdt_checks (
  input logic clk,
  input logic rst,
  input logic cfg_en,
  input logic svc_kick,
  input logic req,
  input logic flag
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!req && !flag)); // R1
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) req |=> !req); // R4
  AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (rst) req |-> flag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) flag |=> flag); // R5
  AST_KICK_NO_REQ: assert property (@(posedge clk) disable iff (rst) svc_kick |=> !req); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst) !cfg_en |=> !req); // R8

endmodule

bind sft_watchdog wdt_checks u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_en   (cfg_en),
  .svc_kick (svc_kick),
  .req      (wdt_rst_req),
  .flag     (wdt_flag)
);

// File: tb/tb_sft_watchdog.sv
module tb_sft_watchdog;

  localparam int PL = 3;
  localparam int EB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b1;
  logic       cfg_pre = 1'b0;
  logic [1:0] cfg_tsel = 2'd0;
  logic       svc_we = 1'b0;
  logic [7:0] svc_data = 8'h00;
  logic       wdt_rst_req;
  logic       wdt_flag;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int cycles = 0;

  sft_watchdog #(.PRE_LOG2(PL), .EXP_BASE(EB)) dut (
    .clk (clk), .rst (rst), .cfg_en (cfg_en), .cfg_pre (cfg_pre),
    .cfg_tsel (cfg_tsel), .svc_we (svc_we), .svc_data (svc_data),
    .wdt_rst_req (wdt_rst_req), .wdt_flag (wdt_flag)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (wdt_rst_req) pulses++;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
    summary();
  end

  function automatic int period(input logic pre, input int t);
    return (pre ? (1 << PL) : 1) * (1 << (EB + 2 * t));
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic en, input logic pre, input int t);
    rst = 1'b1; cfg_en = en; cfg_pre = pre; cfg_tsel = 2'(t);
    svc_we = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    svc_we = 1'b1; svc_data = d;
    step(1);
    svc_we = 1'b0;
  endtask

  task automatic service();
    wr(8'h55);
    wr(8'hAA);
  endtask

  task automatic expect_expiry(input int n, input string req);
    int early = 0;
    for (int i = 0; i < n - 1; i++) begin
      step(1);
      if (wdt_rst_req) early++;
    end
    step(1);
    chk(early == 0 && wdt_rst_req, req, early * 10 + int'(wdt_rst_req), 1);
  endtask

  task automatic t_reset();
    do_reset(1'b1, 1'b0, 0);
    chk(!wdt_rst_req, "R1 req after reset", int'(wdt_rst_req), 0);
    chk(!wdt_flag, "R1 flag after reset", int'(wdt_flag), 0);
  endtask

  task automatic t_direct_rates();
    for (int t = 0; t < 4; t++) begin
      do_reset(1'b1, 1'b0, t);
      expect_expiry(period(1'b0, t), "R2 direct period");
      chk(wdt_flag, "R5 flag set on expiry", int'(wdt_flag), 1);
    end
  endtask

  task automatic t_prescaled_rates();
    for (int t = 0; t < 4; t++) begin
      do_reset(1'b1, 1'b1, t);
      expect_expiry(period(1'b1, t), "R3 prescaled period");
    end
  endtask

  task automatic t_pulse();
    do_reset(1'b1, 1'b0, 0);
    expect_expiry(16, "R4 first expiry");
    step(1);
    chk(!wdt_rst_req, "R4 one-cycle pulse", int'(wdt_rst_req), 0);
    chk(wdt_flag, "R5 flag held", int'(wdt_flag), 1);
    expect_expiry(15, "R4 repeat expiry");
    step(1);
    chk(wdt_flag, "R5 flag after second expiry", int'(wdt_flag), 1);
  endtask

  task automatic t_service();
    int p0;
    do_reset(1'b1, 1'b0, 0);
    p0 = pulses;
    for (int k = 0; k < 6; k++) begin
      step(10);
      service();
    end
    chk(pulses == p0, "R6 serviced no request", pulses - p0, 0);
    expect_expiry(16, "R6 period from service");
    service();
    chk(wdt_flag, "R5 flag survives service", int'(wdt_flag), 1);
  endtask

  task automatic t_broken();
    do_reset(1'b1, 1'b0, 0);
    wr(8'h55); wr(8'h12); wr(8'hAA);
    expect_expiry(13, "R7 broken sequence ignored");
    do_reset(1'b1, 1'b0, 0);
    step(2); wr(8'hAA);
    expect_expiry(13, "R7 lone 0xAA ignored");
    do_reset(1'b1, 1'b0, 0);
    wr(8'h55); step(1); wr(8'hAA);
    expect_expiry(16, "R6 idle gap in sequence");
    do_reset(1'b1, 1'b0, 0);
    wr(8'h55); wr(8'h55); wr(8'hAA);
    expect_expiry(16, "R7 repeated 0x55 stays armed");
  endtask

  task automatic t_enable();
    int p0;
    do_reset(1'b0, 1'b0, 0);
    p0 = pulses;
    step(100);
    chk(pulses == p0, "R8 disabled no request", pulses - p0, 0);
    cfg_en = 1'b1;
    expect_expiry(16, "R8 count from enable");
    do_reset(1'b1, 1'b0, 0);
    step(10);
    cfg_en = 1'b0;
    step(5);
    cfg_en = 1'b1;
    expect_expiry(16, "R8 disable clears count");
  endtask

  task automatic t_cfg_change();
    do_reset(1'b1, 1'b0, 0);
    step(3);
    cfg_tsel = 2'd3;
    expect_expiry(13, "R9 mid-count change ignored");
    expect_expiry(1024, "R9 captured at expiry");
    do_reset(1'b1, 1'b0, 0);
    step(2);
    cfg_tsel = 2'd1;
    service();
    expect_expiry(64, "R9 captured at service");
  endtask

  initial begin
    t_reset();
    t_direct_rates();
    t_prescaled_rates();
    t_pulse();
    t_service();
    t_broken();
    t_enable();
    t_cfg_change();
    summary();
  end

endmodule